// File: doc/BRIEF.md
# CAN Bus Front-End with Self-Test Loopback and Wake-Up Detection

This block stands between a CAN protocol engine and the two bus pins. It holds a three-bit mode register that selects a loopback self-test path, a wake-up detection style, and a clock-source choice. In normal operation the engine's transmit stream drives the TX pin and the RX pin feeds the engine's receiver. In loopback the transmit stream goes straight back into the receiver. The TX pin stays recessive, and the acknowledge slot is forced dominant so that the engine accepts its own frame as though another node had sent it.

While the controller sleeps, the block watches the RX pin through a two-flop synchronizer and raises a sticky wake-up request. It can do this on any falling edge of the pin. It can also require a dominant pulse that lasts at least a set number of clock cycles, so that short glitches are rejected. The mode register accepts writes only while the soft-reset status input is high. The clock-source bit is only stored and brought out as a select line.

Top module: `canfe_frontend`

## Requirements
- R1: After synchronous reset, `mode_rdata` reads 0x00. Bits 7 to 3 of `mode_rdata` always read 0.
- R2: A write (`mode_wr`=1) loads `mode_wdata` into the register at the clock edge only when `soft_rst`=1. With `soft_rst`=0 the write leaves `mode_rdata` unchanged.
- R3: With loopback set (register bit 2 = 1) and `ack_slot`=0, `rx_bit` equals `tx_bit`, whatever the value of `rx_pin`.
- R4: With loopback set, `tx_pin` is 1 (recessive). With loopback clear, `tx_pin` equals `tx_bit` and `rx_bit` equals `rx_pin`.
- R5: With loopback set and `ack_slot`=1, `rx_bit` is 0 (dominant), whatever the value of `tx_bit`.
- R6: `tx_done_irq` equals `tx_done_in` and `rx_done_irq` equals `rx_done_in` in both normal and loopback operation.
- R7: With wake mode 0 (bit 1 = 0) and `sleep`=1, a 1-to-0 change of `rx_pin` sets `wake_req` on the third rising clock edge after the change. This holds even for a one-cycle glitch.
- R8: With wake mode 1 (bit 1 = 1) and `sleep`=1, `wake_req` is set only when `rx_pin` stays at 0 for at least MIN_LEN consecutive cycles. A pulse of MIN_LEN-1 cycles leaves `wake_req` at 0.
- R9: `wake_req` is sticky while `sleep`=1. It is cleared at the next edge by `wake_clr`=1 or by `sleep`=0, and clearing takes priority over setting. It is never set while `sleep`=0.
- R10: `clk_sel` always equals register bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Write data: bit 2 loopback, bit 1 wake mode, bit 0 clock select |
| soft_rst | input | 1 | Controller soft-reset status; writes are accepted only when 1 |
| mode_rdata | output | 8 | Register readback, upper five bits zero |
| tx_bit | input | 1 | Transmit bit stream from the protocol engine |
| rx_bit | output | 1 | Receive bit stream to the protocol engine |
| tx_pin | output | 1 | Bus transmit pin |
| rx_pin | input | 1 | Bus receive pin |
| ack_slot | input | 1 | High while the engine samples the acknowledge slot |
| tx_done_in | input | 1 | Transmit-complete strobe from the engine |
| rx_done_in | input | 1 | Receive-complete strobe from the engine |
| tx_done_irq | output | 1 | Transmit-complete interrupt strobe |
| rx_done_irq | output | 1 | Receive-complete interrupt strobe |
| sleep | input | 1 | Controller sleep state; enables wake-up detection |
| wake_clr | input | 1 | Clears the wake-up request |
| wake_req | output | 1 | Sticky wake-up request |
| clk_sel | output | 1 | Exported clock-source select |

## Verification
The bench goes after the register lock. A design that ignored `soft_rst` would take the bench's write of 0x7 made with the lock closed, and `mode_rdata` would differ from the model at once. In loopback it drives `rx_pin` against `tx_bit` and pulses `ack_slot`. A leaking RX pin, a TX pin that follows the stream, or an unmasked acknowledge bit all show up as a mismatch on the combinational outputs. For the filtered wake-up it sends dominant pulses of exactly MIN_LEN-1 and MIN_LEN cycles. A counter that is off by one wakes on the short pulse or misses the long one, and a missing synchronizer stage moves the wake edge by one cycle. It also checks that a falling edge outside sleep and a clear that arrives together with a set both leave `wake_req` low.

// File: rtl/canfe_pkg.sv
package canfe_pkg;

    localparam int MODE_W = 3;
    localparam int READ_W = 8;

    typedef struct packed {
        logic loopback;
        logic wake_filt;
        logic clk_sel;
    } mode_t;

    typedef struct packed {
        logic tx_done;
        logic rx_done;
    } irq_t;

    localparam mode_t MODE_RESET = '{loopback: 1'b0, wake_filt: 1'b0, clk_sel: 1'b0};

    function automatic logic [READ_W-1:0] mode_readback(mode_t m);
        return {{(READ_W-MODE_W){1'b0}}, m};
    endfunction

    function automatic mode_t mode_from_bits(logic [MODE_W-1:0] b);
        return mode_t'(b);
    endfunction

endpackage

// File: rtl/canfe_modereg.sv
module canfe_modereg
    import canfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    input  logic              unlocked,
    output mode_t             mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RESET;
        end else if (wr && unlocked) begin
            mode <= mode_from_bits(wdata);
        end
    end

endmodule

// File: rtl/canfe_route.sv
module canfe_route
    import canfe_pkg::*;
(
    input  logic loopback,
    input  logic tx_bit,
    input  logic rx_pin,
    input  logic ack_slot,
    input  irq_t irq_in,
    output logic tx_pin,
    output logic rx_bit,
    output irq_t irq_out
);

    always_comb begin
        if (loopback) begin
            tx_pin = 1'b1;
            rx_bit = ack_slot ? 1'b0 : tx_bit;
        end else begin
            tx_pin = tx_bit;
            rx_bit = rx_pin;
        end
        irq_out = irq_in;
    end

endmodule

// File: rtl/canfe_wake.sv
module canfe_wake #(
    parameter int MIN_LEN     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_pin,
    input  logic sleep,
    input  logic wake_filt,
    input  logic wake_clr,
    output logic wake_req
);

    localparam int CNT_W = (MIN_LEN > 1) ? $clog2(MIN_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_LEN - 1);

    // sh[SYNC_STAGES-1] is the synchronized pin, sh[SYNC_STAGES] its previous value
    logic [SYNC_STAGES:0] sh;
    logic                 synced, prev, edge_hit, pulse_hit, hit;
    logic [CNT_W-1:0]     run;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[SYNC_STAGES-1:0], rx_pin};
    end

    assign synced = sh[SYNC_STAGES-1];
    assign prev   = sh[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst || !sleep || synced) begin
            run <= '0;
        end else if (run != CNT_TOP) begin
            run <= run + 1'b1;
        end
    end

    always_comb begin
        edge_hit  = prev && !synced;
        pulse_hit = !synced && (run == CNT_TOP);
        hit       = sleep && (wake_filt ? pulse_hit : edge_hit);
    end

    always_ff @(posedge clk) begin
        if (rst || !sleep || wake_clr) wake_req <= 1'b0;
        else if (hit)                  wake_req <= 1'b1;
    end

endmodule

// File: rtl/canfe_frontend.sv
module canfe_frontend
    import canfe_pkg::*;
#(
    parameter int MIN_LEN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              soft_rst,
    output logic [READ_W-1:0] mode_rdata,
    input  logic              tx_bit,
    output logic              rx_bit,
    output logic              tx_pin,
    input  logic              rx_pin,
    input  logic              ack_slot,
    input  logic              tx_done_in,
    input  logic              rx_done_in,
    output logic              tx_done_irq,
    output logic              rx_done_irq,
    input  logic              sleep,
    input  logic              wake_clr,
    output logic              wake_req,
    output logic              clk_sel
);

    mode_t mode;
    irq_t  irq_in, irq_out;

    canfe_modereg u_modereg (
        .clk      (clk),
        .rst      (rst),
        .wr       (mode_wr),
        .wdata    (mode_wdata),
        .unlocked (soft_rst),
        .mode     (mode)
    );

    assign irq_in = '{tx_done: tx_done_in, rx_done: rx_done_in};

    canfe_route u_route (
        .loopback (mode.loopback),
        .tx_bit   (tx_bit),
        .rx_pin   (rx_pin),
        .ack_slot (ack_slot),
        .irq_in   (irq_in),
        .tx_pin   (tx_pin),
        .rx_bit   (rx_bit),
        .irq_out  (irq_out)
    );

    canfe_wake #(.MIN_LEN(MIN_LEN), .SYNC_STAGES(2)) u_wake (
        .clk       (clk),
        .rst       (rst),
        .rx_pin    (rx_pin),
        .sleep     (sleep),
        .wake_filt (mode.wake_filt),
        .wake_clr  (wake_clr),
        .wake_req  (wake_req)
    );

    assign tx_done_irq = irq_out.tx_done;
    assign rx_done_irq = irq_out.rx_done;
    assign mode_rdata  = mode_readback(mode);
    assign clk_sel     = mode.clk_sel;

endmodule

// File: rtl/canfe_frontend_chk.sv
module canfe_frontend_chk (
    input logic       clk,
    input logic       rst,
    input logic       soft_rst,
    input logic [7:0] mode_rdata,
    input logic       tx_bit,
    input logic       rx_bit,
    input logic       tx_pin,
    input logic       ack_slot,
    input logic       sleep,
    input logic       wake_clr,
    input logic       wake_req,
    input logic       clk_sel
);

    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        mode_rdata[7:3] == 5'b0);

    a_r2_locked: assert property (@(posedge clk) disable iff (rst)
        !soft_rst |=> $stable(mode_rdata));

    a_r4_loop_recessive: assert property (@(posedge clk) disable iff (rst)
        mode_rdata[2] |-> tx_pin);

    a_r3_loop_path: assert property (@(posedge clk) disable iff (rst)
        (mode_rdata[2] && !ack_slot) |-> (rx_bit == tx_bit));

    a_r5_ack_dominant: assert property (@(posedge clk) disable iff (rst)
        (mode_rdata[2] && ack_slot) |-> !rx_bit);

    a_r9_awake_clear: assert property (@(posedge clk) disable iff (rst)
        !sleep |=> !wake_req);

    a_r9_strobe_clear: assert property (@(posedge clk) disable iff (rst)
        wake_clr |=> !wake_req);

    a_r10_clk_sel: assert property (@(posedge clk) disable iff (rst)
        clk_sel == mode_rdata[0]);

endmodule

bind canfe_frontend canfe_frontend_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .mode_rdata (mode_rdata),
    .tx_bit     (tx_bit),
    .rx_bit     (rx_bit),
    .tx_pin     (tx_pin),
    .ack_slot   (ack_slot),
    .sleep      (sleep),
    .wake_clr   (wake_clr),
    .wake_req   (wake_req),
    .clk_sel    (clk_sel)
);

// File: tb/canfe_frontend_bench.sv
`timescale 1ns/1ps
module canfe_frontend_bench;

    localparam int CLK_P   = 10;
    localparam int MIN_LEN = 8;

    logic       clk = 0;
    logic       rst = 1;
    logic       mode_wr = 0;
    logic [2:0] mode_wdata = 0;
    logic       soft_rst = 0;
    logic [7:0] mode_rdata;
    logic       tx_bit = 1, rx_bit, tx_pin, rx_pin = 1, ack_slot = 0;
    logic       tx_done_in = 0, rx_done_in = 0, tx_done_irq, rx_done_irq;
    logic       sleep = 0, wake_clr = 0, wake_req, clk_sel;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    canfe_frontend #(.MIN_LEN(MIN_LEN)) u_canfe_frontend (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .soft_rst(soft_rst), .mode_rdata(mode_rdata), .tx_bit(tx_bit),
        .rx_bit(rx_bit), .tx_pin(tx_pin), .rx_pin(rx_pin), .ack_slot(ack_slot),
        .tx_done_in(tx_done_in), .rx_done_in(rx_done_in),
        .tx_done_irq(tx_done_irq), .rx_done_irq(rx_done_irq),
        .sleep(sleep), .wake_clr(wake_clr), .wake_req(wake_req), .clk_sel(clk_sel)
    );

    // behavioural reference model
    int   m_mode = 0;
    int   m_run  = 0;
    bit   m_wake = 0;
    bit   m_hist[$] = '{1, 1, 1};   // [0] first flop, [1] synced, [2] previous

    always @(posedge clk) begin
        bit s, p, hit;
        if (rst) begin
            m_mode = 0; m_run = 0; m_wake = 0; m_hist = '{1, 1, 1};
        end else begin
            s = m_hist[1];
            p = m_hist[2];
            if ((m_mode & 2) != 0) hit = sleep && !s && (m_run == MIN_LEN - 1);
            else                   hit = sleep && p && !s;
            if (!sleep || wake_clr) m_wake = 0;
            else if (hit)           m_wake = 1;
            if (!sleep || s)              m_run = 0;
            else if (m_run < MIN_LEN - 1) m_run = m_run + 1;
            if (mode_wr && soft_rst) m_mode = mode_wdata;
            m_hist.push_front(rx_pin);
            void'(m_hist.pop_back());
        end
    end

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit lb;
        #(CLK_P/4);
        if (!rst && !done) begin
            lb = (m_mode & 4) != 0;
            check("R1/R2 mode_rdata", mode_rdata, m_mode);
            check("R10 clk_sel", clk_sel, m_mode & 1);
            check("R4 tx_pin", tx_pin, lb ? 1 : tx_bit);
            check("R3/R4/R5 rx_bit", rx_bit, lb ? (ack_slot ? 0 : tx_bit) : rx_pin);
            check("R6 tx_done_irq", tx_done_irq, tx_done_in);
            check("R6 rx_done_irq", rx_done_irq, rx_done_in);
            check("R7/R8/R9 wake_req", wake_req, m_wake);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(logic [2:0] v, logic unlock);
        @(negedge clk);
        mode_wr = 1; mode_wdata = v; soft_rst = unlock;
        @(negedge clk);
        mode_wr = 0; soft_rst = 0;
    endtask

    task automatic dominant_pulse(int len);
        @(negedge clk);
        rx_pin = 0;
        tick(len);
        rx_pin = 1;
    endtask

    initial begin
        fork
            begin : watchdog
                #(CLK_P * 20000);
                fails++; tests++;
                $display("FAIL watchdog expired");
            end
            begin : stim
                tick(3);
                @(negedge clk) rst = 0;
                tick(1);
                // R1: reset value
                tests++; if (mode_rdata != 8'h00) begin fails++; $display("FAIL R1 actual %0h expected 0", mode_rdata); end
                // R2: locked write ignored, unlocked accepted
                write_mode(3'b111, 0); tick(2);
                write_mode(3'b111, 1); tick(2);
                write_mode(3'b001, 1); tick(2);
                write_mode(3'b100, 0); tick(2);
                // R4/R6 normal routing with varied patterns
                for (int i = 0; i < 16; i++) begin
                    @(negedge clk);
                    tx_bit = i[0]; rx_pin = i[1]; tx_done_in = i[2]; rx_done_in = i[3];
                end
                rx_pin = 1; tx_done_in = 0; rx_done_in = 0;
                // R3/R5 loopback
                write_mode(3'b100, 1);
                for (int i = 0; i < 16; i++) begin
                    @(negedge clk);
                    tx_bit = i[0]; rx_pin = i[1]; ack_slot = i[2]; tx_done_in = i[3]; rx_done_in = i[0];
                end
                ack_slot = 0; rx_pin = 1; tx_bit = 1; tx_done_in = 0; rx_done_in = 0;
                // R7: edge wake, including one-cycle glitch
                write_mode(3'b000, 1);
                dominant_pulse(2); tick(5);          // not asleep: no wake (R9)
                @(negedge clk) sleep = 1;
                dominant_pulse(1); tick(5);
                tests++; if (wake_req !== 1'b1) begin fails++; $display("FAIL R7 actual %0b expected 1", wake_req); end
                @(negedge clk) wake_clr = 1;
                @(negedge clk) wake_clr = 0;
                tick(2);
                // R9: clear wins over set
                @(negedge clk) rx_pin = 0;
                tick(1); wake_clr = 1;
                tick(4); wake_clr = 0; rx_pin = 1;
                tick(3);
                @(negedge clk) sleep = 0;
                tick(2);
                // R8: filtered wake
                write_mode(3'b010, 1);
                @(negedge clk) sleep = 1;
                dominant_pulse(MIN_LEN - 1); tick(6);
                tests++; if (wake_req !== 1'b0) begin fails++; $display("FAIL R8 short pulse actual %0b expected 0", wake_req); end
                dominant_pulse(MIN_LEN); tick(6);
                tests++; if (wake_req !== 1'b1) begin fails++; $display("FAIL R8 full pulse actual %0b expected 1", wake_req); end
                @(negedge clk) sleep = 0;
                tick(3);
                tests++; if (wake_req !== 1'b0) begin fails++; $display("FAIL R9 sleep exit actual %0b expected 0", wake_req); end
                tick(2);
                done = 1;
                disable watchdog;
            end
        join
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule